// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the fetch state of every hardware thread of a multithreaded front end and moves it forward once per clock. Four downstream stages (decode, rename, execute, commit) each raise block and unblock pulses per thread. The controller latches these pulses into sticky per-thread stall bits. Squash requests from commit and decode redirect a thread's fetch address, and commit can hold a thread in the squashing state while it drains. A context-switch flag stalls every thread at once.

Cache activity reaches the block as events. Either the fetch selector picks a thread and reports how its access went, or a retry or a line fill comes back for a waiting thread. Fills that arrive for a thread no longer waiting are stale and are dropped. The block reports the state of each thread, its current and next fetch address, a one-cycle redirect marker, and a stage-active flag. The surrounding core uses that flag to decide whether the fetch stage needs clocking work at all.

Within one cycle a thread's events are applied in a fixed order. Cache returns come first, then the downstream signals in priority order, then the outcome of fetch selection on the resulting state.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread is Running, all stall bits are clear, the fetch address is 0 and the next address is 4. State codes on `thr_state_o` (4 bits per thread, thread t at bits 4t+3..4t) are: Running 0, Idle 1, Squashing 2, Blocked 3, WaitRetry 4, WaitResponse 5, AccessComplete 6, TrapPending 7, QuiescePending 8.
- R2: Each thread has four sticky stall bits, one per stage, at index 4t+s of `blk_set_i`/`blk_clr_i`, with s = 0 decode, 1 rename, 2 execute, 3 commit. A block pulse sets its bit. Only an unblock pulse clears it.
- R3: A thread is stalled when `ctx_switch_i` is high or any of its stall bits (after this cycle's pulses) is set. A stalled thread that is not in WaitResponse, and that no squash or squash-busy flag hits, becomes Blocked. A thread in Blocked or Squashing with no stall and no squash returns to Running.
- R4: A commit squash has top priority. The thread goes to Squashing, its fetch address becomes the commit address and its next address that value plus 4, and `redirect_o` is high for that thread in the following cycle.
- R5: When no commit squash is present, commit's still-squashing flag forces Squashing. It outranks a decode squash, whose address is then not taken.
- R6: A decode squash redirects the thread (address, next address plus 4, redirect marker) and sets Squashing, but only if the thread was not already Squashing.
- R7: A selected Running thread goes to WaitResponse when `fetch_res_i` is 0 (accepted) and to WaitRetry when it is 1 (refused). A retry event moves WaitRetry to WaitResponse. A fill moves WaitResponse to AccessComplete, or to Blocked if the thread is stalled. A fill for a thread in any other state has no effect.
- R8: A thread in AccessComplete that is selected becomes Running.
- R9: A selected Running thread goes to TrapPending when `fetch_res_i` is 2 and to QuiescePending when it is 3. These states hold until a squash or a stall.
- R10: A block and an unblock pulse for the same stage and thread in the same cycle raise `proto_err_o` in that cycle, and the unblock is ignored (the bit ends set).
- R11: `stage_active_o` is high exactly when some thread marked in `thr_active_i` is Running, Squashing or AccessComplete.
- R12: A thread whose `thr_active_i` bit is low ignores block, unblock, squash and selection inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_active_i | input | NUM_THREADS | Threads that take part this cycle |
| blk_set_i | input | NUM_THREADS*4 | Block pulses, index 4t+stage |
| blk_clr_i | input | NUM_THREADS*4 | Unblock pulses, index 4t+stage |
| ctx_switch_i | input | 1 | Context switch in progress (stalls all threads) |
| cmt_squash_i | input | NUM_THREADS | Squash request from commit |
| cmt_pc_i | input | NUM_THREADS*PC_W | Commit redirect address per thread |
| cmt_busy_i | input | NUM_THREADS | Commit still squashing |
| dec_squash_i | input | NUM_THREADS | Squash request from decode |
| dec_pc_i | input | NUM_THREADS*PC_W | Decode redirect address per thread |
| fetch_sel_i | input | NUM_THREADS | Thread picked by the fetch selector |
| fetch_res_i | input | 2 | Outcome for picked thread: 0 accepted, 1 refused, 2 trap, 3 quiesce |
| fill_i | input | NUM_THREADS | Cache line returned |
| retry_i | input | NUM_THREADS | Refused access now accepted |
| thr_state_o | output | NUM_THREADS*4 | Per-thread state code |
| fetch_pc_o | output | NUM_THREADS*PC_W | Current fetch address |
| next_pc_o | output | NUM_THREADS*PC_W | Next fetch address |
| redirect_o | output | NUM_THREADS | Address was redirected on the last edge |
| stage_active_o | output | 1 | Some active thread can make progress |
| proto_err_o | output | 1 | Same-cycle block and unblock seen |

## Verification
The central collision is two squash sources reaching one thread in the same cycle. Commit squash arrives together with decode squash, and commit's busy flag together with decode squash. Both pairs are driven on thread 0 with distinct addresses. The result is judged by the state code and by which address, if any, appears on the fetch address output after the edge. A second collision, a block and an unblock for the same stage in one cycle, is judged by the error flag during that cycle and by the thread staying Blocked afterwards.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int NUM_STAGES = 4;
    localparam int STATE_W    = 4;

    typedef enum logic [STATE_W-1:0] {
        FS_RUN     = 4'd0,
        FS_IDLE    = 4'd1,
        FS_SQUASH  = 4'd2,
        FS_BLOCK   = 4'd3,
        FS_WRETRY  = 4'd4,
        FS_WRESP   = 4'd5,
        FS_DONE    = 4'd6,
        FS_TRAP    = 4'd7,
        FS_QUIESCE = 4'd8
    } fstate_e;

    typedef enum logic [1:0] {
        RES_ACCEPT  = 2'd0,
        RES_REFUSE  = 2'd1,
        RES_TRAP    = 2'd2,
        RES_QUIESCE = 2'd3
    } fres_e;

    // Cache-side events that arrive between edges.
    function automatic fstate_e apply_cache(fstate_e s, logic fill, logic retry,
                                            logic stalled);
        fstate_e r = s;
        if (s == FS_WRESP && fill)
            r = stalled ? FS_BLOCK : FS_DONE;
        else if (s == FS_WRETRY && retry)
            r = FS_WRESP;
        return r;
    endfunction

    // State in which a thread can make forward progress.
    function automatic logic can_progress(fstate_e s);
        return (s == FS_RUN) || (s == FS_SQUASH) || (s == FS_DONE);
    endfunction

endpackage

// File: rtl/fsc_stall_bank.sv
module fsc_stall_bank #(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [NS-1:0] set_i,
    input  logic [NS-1:0] clr_i,
    output logic [NS-1:0] bits_o,
    output logic [NS-1:0] nxt_o,
    output logic          err_o
);

    logic [NS-1:0] bits_q;

    always_comb begin
        nxt_o = bits_q;
        if (en) begin
            for (int k = 0; k < NS; k++) begin
                if (set_i[k])
                    nxt_o[k] = 1'b1;
                else if (clr_i[k])
                    nxt_o[k] = 1'b0;
            end
        end
    end

    assign err_o  = en & (|(set_i & clr_i));
    assign bits_o = bits_q;

    always_ff @(posedge clk) begin
        if (rst)
            bits_q <= '0;
        else
            bits_q <= nxt_o;
    end

    generate
        for (genvar g = 0; g < NS; g++) begin : g_chk
            AST_STALL_STICKY: assert property (@(posedge clk) disable iff (rst)
                (bits_q[g] && !(en && clr_i[g])) |=> bits_q[g]);          // R2
            AST_UNBLOCK_IGNORED: assert property (@(posedge clk) disable iff (rst)
                (en && set_i[g] && clr_i[g]) |=> bits_q[g]);              // R10
        end
    endgenerate

endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int INST_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            stalled,
    input  logic            cmt_sq,
    input  logic [PC_W-1:0] cmt_pc,
    input  logic            cmt_busy,
    input  logic            dec_sq,
    input  logic [PC_W-1:0] dec_pc,
    input  logic            sel,
    input  logic [1:0]      res,
    input  logic            fill,
    input  logic            retry,
    output fstate_e         state_o,
    output logic [PC_W-1:0] pc_o,
    output logic [PC_W-1:0] npc_o,
    output logic            redir_o
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

    fstate_e         st_q, s_cache, s_sig, s_nxt;
    logic [PC_W-1:0] pc_q, npc_q;
    logic            redir_q;
    logic            take_redir;
    logic [PC_W-1:0] redir_pc;

    // Step 1: cache returns.
    always_comb s_cache = apply_cache(st_q, fill, retry, stalled);

    // Step 2: downstream signals in priority order.
    always_comb begin
        s_sig      = s_cache;
        take_redir = 1'b0;
        redir_pc   = cmt_pc;
        if (en) begin
            if (cmt_sq) begin
                s_sig      = FS_SQUASH;
                take_redir = 1'b1;
            end else if (cmt_busy) begin
                s_sig = FS_SQUASH;
            end else if (dec_sq && s_cache != FS_SQUASH) begin
                s_sig      = FS_SQUASH;
                take_redir = 1'b1;
                redir_pc   = dec_pc;
            end else if (stalled && s_cache != FS_WRESP) begin
                s_sig = FS_BLOCK;
            end else if (s_cache == FS_BLOCK || s_cache == FS_SQUASH) begin
                s_sig = FS_RUN;
            end
        end
    end

    // Step 3: outcome of fetch selection on the updated state.
    always_comb begin
        s_nxt = s_sig;
        if (en && sel) begin
            if (s_sig == FS_DONE) begin
                s_nxt = FS_RUN;
            end else if (s_sig == FS_RUN) begin
                case (fres_e'(res))
                    RES_ACCEPT:  s_nxt = FS_WRESP;
                    RES_REFUSE:  s_nxt = FS_WRETRY;
                    RES_TRAP:    s_nxt = FS_TRAP;
                    RES_QUIESCE: s_nxt = FS_QUIESCE;
                    default:     s_nxt = FS_RUN;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FS_RUN;
            pc_q    <= '0;
            npc_q   <= STEP;
            redir_q <= 1'b0;
        end else begin
            st_q    <= s_nxt;
            redir_q <= take_redir;
            if (take_redir) begin
                pc_q  <= redir_pc;
                npc_q <= redir_pc + STEP;
            end
        end
    end

    assign state_o = st_q;
    assign pc_o    = pc_q;
    assign npc_o   = npc_q;
    assign redir_o = redir_q;

    AST_CMT_SQUASH_WINS: assert property (@(posedge clk) disable iff (rst)
        (en && cmt_sq) |=> (st_q == FS_SQUASH && pc_q == $past(cmt_pc)));       // R4
    AST_NPC_STEP: assert property (@(posedge clk) disable iff (rst)
        npc_q == pc_q + STEP);                                                  // R4
    AST_BUSY_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (en && !cmt_sq && cmt_busy) |=> (st_q == FS_SQUASH && $stable(pc_q))); // R5
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q == FS_WRESP && !fill && !(en && (cmt_sq || cmt_busy || dec_sq)))
        |=> st_q == FS_WRESP);                                                  // R7
    AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q == FS_TRAP && !(en && (cmt_sq || cmt_busy || dec_sq || stalled)))
        |=> st_q == FS_TRAP);                                                   // R9
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> $stable(pc_q));                                               // R12

endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int PC_W        = 32,
    parameter int INST_BYTES  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_THREADS-1:0]        thr_active_i,
    input  logic [NUM_THREADS*4-1:0]      blk_set_i,
    input  logic [NUM_THREADS*4-1:0]      blk_clr_i,
    input  logic                          ctx_switch_i,
    input  logic [NUM_THREADS-1:0]        cmt_squash_i,
    input  logic [NUM_THREADS*PC_W-1:0]   cmt_pc_i,
    input  logic [NUM_THREADS-1:0]        cmt_busy_i,
    input  logic [NUM_THREADS-1:0]        dec_squash_i,
    input  logic [NUM_THREADS*PC_W-1:0]   dec_pc_i,
    input  logic [NUM_THREADS-1:0]        fetch_sel_i,
    input  logic [1:0]                    fetch_res_i,
    input  logic [NUM_THREADS-1:0]        fill_i,
    input  logic [NUM_THREADS-1:0]        retry_i,
    output logic [NUM_THREADS*4-1:0]      thr_state_o,
    output logic [NUM_THREADS*PC_W-1:0]   fetch_pc_o,
    output logic [NUM_THREADS*PC_W-1:0]   next_pc_o,
    output logic [NUM_THREADS-1:0]        redirect_o,
    output logic                          stage_active_o,
    output logic                          proto_err_o
);

    localparam int NS = NUM_STAGES;

    logic [NUM_THREADS-1:0] err_v;
    logic [NUM_THREADS-1:0] prog_v;

    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
            logic [NS-1:0] bits, nxt;
            logic          stalled;
            fstate_e       st;

            fsc_stall_bank #(.NS(NS)) u_bank (
                .clk    (clk),
                .rst    (rst),
                .en     (thr_active_i[t]),
                .set_i  (blk_set_i[t*NS +: NS]),
                .clr_i  (blk_clr_i[t*NS +: NS]),
                .bits_o (bits),
                .nxt_o  (nxt),
                .err_o  (err_v[t])
            );

            assign stalled = ctx_switch_i | (|nxt);

            fsc_thread_fsm #(.PC_W(PC_W), .INST_BYTES(INST_BYTES)) u_fsm (
                .clk      (clk),
                .rst      (rst),
                .en       (thr_active_i[t]),
                .stalled  (stalled),
                .cmt_sq   (cmt_squash_i[t]),
                .cmt_pc   (cmt_pc_i[t*PC_W +: PC_W]),
                .cmt_busy (cmt_busy_i[t]),
                .dec_sq   (dec_squash_i[t]),
                .dec_pc   (dec_pc_i[t*PC_W +: PC_W]),
                .sel      (fetch_sel_i[t]),
                .res      (fetch_res_i),
                .fill     (fill_i[t]),
                .retry    (retry_i[t]),
                .state_o  (st),
                .pc_o     (fetch_pc_o[t*PC_W +: PC_W]),
                .npc_o    (next_pc_o[t*PC_W +: PC_W]),
                .redir_o  (redirect_o[t])
            );

            assign thr_state_o[t*4 +: 4] = st;
            assign prog_v[t]             = thr_active_i[t] & can_progress(st);

            AST_BLOCK_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
                (thr_active_i[t] && |bits && !blk_clr_i[t*NS +: NS] && !cmt_squash_i[t]
                 && !cmt_busy_i[t] && !dec_squash_i[t] && st != FS_WRESP)
                |=> (st == FS_BLOCK));                                          // R3
        end
    endgenerate

    assign stage_active_o = |prog_v;
    assign proto_err_o    = |err_v;

endmodule

// File: tb/fetch_status_ctrl_tb.sv
module fetch_status_ctrl_tb_top;

    localparam int NT = 2;
    localparam int PW = 32;
    localparam int NV = 31;

    logic             clk = 1'b0;
    logic             rst;
    logic [NT-1:0]    act;
    logic [NT*4-1:0]  bset, bclr;
    logic             ctx;
    logic [NT-1:0]    csq, cbusy, dsq, sel, fill, retry;
    logic [NT*PW-1:0] cpc, dpc;
    logic [1:0]       res;
    logic [NT*4-1:0]  st;
    logic [NT*PW-1:0] pc, npc;
    logic [NT-1:0]    redir;
    logic             sact, perr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fetch_status_ctrl #(.NUM_THREADS(NT), .PC_W(PW), .INST_BYTES(4)) dut_i (
        .clk(clk), .rst(rst), .thr_active_i(act), .blk_set_i(bset), .blk_clr_i(bclr),
        .ctx_switch_i(ctx), .cmt_squash_i(csq), .cmt_pc_i(cpc), .cmt_busy_i(cbusy),
        .dec_squash_i(dsq), .dec_pc_i(dpc), .fetch_sel_i(sel), .fetch_res_i(res),
        .fill_i(fill), .retry_i(retry), .thr_state_o(st), .fetch_pc_o(pc),
        .next_pc_o(npc), .redirect_o(redir), .stage_active_o(sact), .proto_err_o(perr)
    );

    // {set[3:0], clr[3:0], ctx csq busy dsq sel res[1:0], fill retry, exp_state[3:0], exp_err}
    localparam logic [21:0] VEC [NV] = '{
        {4'b0000, 4'b0000, 7'b0000100, 2'b00, 4'd5, 1'b0},   // R7 accept
        {4'b0000, 4'b0000, 7'b0000000, 2'b10, 4'd6, 1'b0},   // R7 fill
        {4'b0000, 4'b0000, 7'b0000100, 2'b00, 4'd0, 1'b0},   // R8
        {4'b0001, 4'b0000, 7'b0000000, 2'b00, 4'd3, 1'b0},   // R3 block decode
        {4'b0000, 4'b0000, 7'b0000100, 2'b00, 4'd3, 1'b0},   // R2 sticky
        {4'b0000, 4'b0001, 7'b0000000, 2'b00, 4'd0, 1'b0},   // R2 unblock
        {4'b0010, 4'b0010, 7'b0000000, 2'b00, 4'd3, 1'b1},   // R10
        {4'b0000, 4'b0010, 7'b0000000, 2'b00, 4'd0, 1'b0},   // R10 clear
        {4'b0000, 4'b0000, 7'b0000101, 2'b00, 4'd4, 1'b0},   // R7 refuse
        {4'b0000, 4'b0000, 7'b0000000, 2'b01, 4'd5, 1'b0},   // R7 retry
        {4'b0100, 4'b0000, 7'b0000000, 2'b00, 4'd5, 1'b0},   // R3 wait exempt
        {4'b0000, 4'b0000, 7'b0000000, 2'b10, 4'd3, 1'b0},   // R7 fill stalled
        {4'b0000, 4'b0100, 7'b0000000, 2'b00, 4'd0, 1'b0},   // R3
        {4'b0000, 4'b0000, 7'b0000100, 2'b00, 4'd5, 1'b0},   // R7
        {4'b0000, 4'b0000, 7'b0001000, 2'b00, 4'd2, 1'b0},   // R6
        {4'b0000, 4'b0000, 7'b0000000, 2'b10, 4'd0, 1'b0},   // R7 stale fill
        {4'b0000, 4'b0000, 7'b0010000, 2'b00, 4'd2, 1'b0},   // R5
        {4'b0000, 4'b0000, 7'b0011000, 2'b00, 4'd2, 1'b0},   // R5 over decode
        {4'b0000, 4'b0000, 7'b0001000, 2'b00, 4'd0, 1'b0},   // R6 skipped
        {4'b1000, 4'b0000, 7'b0100000, 2'b00, 4'd2, 1'b0},   // R4 over stall
        {4'b0000, 4'b0000, 7'b0000000, 2'b00, 4'd3, 1'b0},   // R2 commit bit
        {4'b0000, 4'b1000, 7'b0000000, 2'b00, 4'd0, 1'b0},   // R3
        {4'b0000, 4'b0000, 7'b1000000, 2'b00, 4'd3, 1'b0},   // R3 ctx
        {4'b0000, 4'b0000, 7'b0000000, 2'b00, 4'd0, 1'b0},   // R3
        {4'b0000, 4'b0000, 7'b0000110, 2'b00, 4'd7, 1'b0},   // R9 trap
        {4'b0000, 4'b0000, 7'b0000100, 2'b00, 4'd7, 1'b0},   // R9 hold
        {4'b0000, 4'b0000, 7'b0100000, 2'b00, 4'd2, 1'b0},   // R4
        {4'b0000, 4'b0000, 7'b0000000, 2'b00, 4'd0, 1'b0},   // R3
        {4'b0000, 4'b0000, 7'b0000111, 2'b00, 4'd8, 1'b0},   // R9 quiesce
        {4'b0000, 4'b0000, 7'b0100000, 2'b00, 4'd2, 1'b0},   // R4
        {4'b0000, 4'b0000, 7'b0000000, 2'b00, 4'd0, 1'b0}    // R3
    };

    task automatic chk(input string tag, input logic [63:0] a, input logic [63:0] e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    task automatic idle_inputs();
        bset = '0; bclr = '0; ctx = 1'b0; csq = '0; cbusy = '0; dsq = '0;
        sel = '0; res = 2'd0; fill = '0; retry = '0;
        cpc = {32'h0, 32'h100}; dpc = {32'h0, 32'h200};
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        act = 2'b01;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 state", 64'(st), 64'h00);
        chk("R1 pc", 64'(pc), 64'h0);
        chk("R1 npc", 64'(npc), {32'h4, 32'h4});
        chk("R11 active after reset", 64'(sact), 64'h1);
        chk("R1 no error", 64'(perr), 64'h0);

        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            logic [3:0]  e;
            v = VEC[i];
            @(negedge clk);
            idle_inputs();
            bset[3:0] = v[21:18];
            bclr[3:0] = v[17:14];
            ctx       = v[13];
            csq[0]    = v[12];
            cbusy[0]  = v[11];
            dsq[0]    = v[10];
            sel[0]    = v[9];
            res       = v[8:7];
            fill[0]   = v[6];
            retry[0]  = v[5];
            e         = v[4:1];
            #1;
            chk($sformatf("R10 err vec %0d", i), 64'(perr), 64'(v[0]));
            tick();
            chk($sformatf("R3 state vec %0d", i), 64'(st[3:0]), 64'(e));
            chk($sformatf("R12 idle thread vec %0d", i), 64'(st[7:4]), 64'h0);
            chk($sformatf("R11 active vec %0d", i), 64'(sact),
                64'(e == 4'd0 || e == 4'd2 || e == 4'd6));
        end

        // R6 decode redirect address
        @(negedge clk); idle_inputs();
        dsq[0] = 1'b1; dpc[31:0] = 32'h2000;
        tick();
        chk("R6 pc", 64'(pc[31:0]), 64'h2000);
        chk("R6 npc", 64'(npc[31:0]), 64'h2004);
        chk("R6 redirect", 64'(redir[0]), 64'h1);
        @(negedge clk); idle_inputs();
        tick();
        chk("R6 back to running", 64'(st[3:0]), 64'h0);
        chk("R4 redirect is a pulse", 64'(redir[0]), 64'h0);

        // R4 commit beats decode in the same cycle
        @(negedge clk); idle_inputs();
        csq[0] = 1'b1; cpc[31:0] = 32'h3000;
        dsq[0] = 1'b1; dpc[31:0] = 32'h4000;
        tick();
        chk("R4 pc commit wins", 64'(pc[31:0]), 64'h3000);
        chk("R4 npc", 64'(npc[31:0]), 64'h3004);
        chk("R4 state", 64'(st[3:0]), 64'h2);
        @(negedge clk); idle_inputs();
        tick();

        // R5 busy beats decode, no redirect
        @(negedge clk); idle_inputs();
        cbusy[0] = 1'b1; dsq[0] = 1'b1; dpc[31:0] = 32'h5000;
        tick();
        chk("R5 pc kept", 64'(pc[31:0]), 64'h3000);
        chk("R5 no redirect", 64'(redir[0]), 64'h0);
        chk("R5 state", 64'(st[3:0]), 64'h2);
        @(negedge clk); idle_inputs();
        tick();

        // R12 inactive thread ignores block and squash
        @(negedge clk); idle_inputs();
        bset[4] = 1'b1; csq[1] = 1'b1; cpc[63:32] = 32'h7000;
        tick();
        chk("R12 state t1", 64'(st[7:4]), 64'h0);
        chk("R12 pc t1", 64'(pc[63:32]), 64'h0);
        @(negedge clk); idle_inputs();
        act = 2'b11;
        tick();
        chk("R12 no latched stall t1", 64'(st[7:4]), 64'h0);
        chk("R11 both active", 64'(sact), 64'h1);

        // R11 everything blocked by context switch
        @(negedge clk); idle_inputs();
        ctx = 1'b1;
        tick();
        chk("R3 ctx blocks t0", 64'(st[3:0]), 64'h3);
        chk("R3 ctx blocks t1", 64'(st[7:4]), 64'h3);
        chk("R11 stage idle", 64'(sact), 64'h0);
        @(negedge clk); idle_inputs();
        tick();
        chk("R11 stage active again", 64'(sact), 64'h1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule